// File: doc/BRIEF.md
# Warp Activity Control Unit

This unit keeps two per-core bit vectors with one bit per warp. The active mask says which warps may be scheduled. The stalled mask says which warps are held back at fetch. The unit takes warp-control instructions over a valid/ready input. Each instruction carries an operation code, the issuing warp number, a warp-mask operand and a fetch-stall flag. An accepted instruction updates the masks at the clock edge where it is accepted. It then raises a completion strobe for one cycle, tagged with the issuing warp.

Each operation has its own update rule:
- Thread-mask control copies one bit of the operand into the issuer's active bit.
- Spawn overwrites the whole active mask.
- Barrier merges the operand into the active mask, or clears the issuer's bit when the operand is empty.
- Split and join only complete.

A separate fetch-side strobe marks a warp as stalled. An instruction issued with its fetch-stall flag set releases that warp. An undefined operation code, or a warp number at or above the configured warp count, is rejected with an error strobe.

Top module: `warp_ctl_unit`

## Requirements
- R1: After reset, active_mask_o is 1 (only warp 0 active), stalled_mask_o is 0, and done_valid_o, err_op_o and err_wid_o are low. in_ready_o is high from the first clock edge after reset is released.
- R2: Thread-mask control (op code 0) sets active bit in_wid_i to in_wmask_i[in_wid_i] and leaves every other active bit unchanged.
- R3: Spawn (op code 1) replaces the whole active mask with in_wmask_i.
- R4: Barrier (op code 4) ORs a non-zero in_wmask_i into the active mask. With a zero in_wmask_i, it clears active bit in_wid_i.
- R5: Split (op code 2) and join (op code 3) leave both masks unchanged. The same holds for any cycle without an accepted instruction.
- R6: Every accepted instruction with a legal op code and an in-range warp raises done_valid_o for exactly the next cycle, with done_wid_o equal to its in_wid_i.
- R7: A legal, in-range accepted instruction with in_fstall_i set clears stalled bit in_wid_i. stall_set_i sets stalled bit stall_set_wid_i when that warp is in range. When the same bit is set and cleared in one cycle, the clear wins.
- R8: Op codes 5, 6 and 7 are illegal. An accepted illegal instruction changes no mask and gives no completion, and it raises err_op_o for the next cycle.
- R9: An accepted instruction with in_wid_i >= NUM_WARPS changes no mask and gives no completion, and it raises err_wid_o for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction valid |
| in_ready_o | output | 1 | Unit can accept an instruction |
| in_op_i | input | 3 | Operation code |
| in_wid_i | input | WID_W | Issuing warp number |
| in_wmask_i | input | NUM_WARPS | Warp-mask operand |
| in_fstall_i | input | 1 | Issuer was fetch-stalled; release it |
| stall_set_i | input | 1 | Mark a warp as stalled |
| stall_set_wid_i | input | WID_W | Warp to mark as stalled |
| active_mask_o | output | NUM_WARPS | Active-warp mask |
| stalled_mask_o | output | NUM_WARPS | Stalled-warp mask |
| done_valid_o | output | 1 | Completion strobe |
| done_wid_o | output | WID_W | Warp of the completed instruction |
| err_op_o | output | 1 | Illegal op code was accepted |
| err_wid_o | output | 1 | Out-of-range warp was accepted |

## Verification
The hardest case to reach from the ports is a stall mark and a release landing on the same warp in the same cycle. Only then does the set/clear priority of the stalled mask become visible. The directed phase forces this case by raising stall_set_i together with a fetch-stall instruction for the same warp. It also pairs out-of-range warps and illegal op codes with non-zero operands, so that a leaked update would show up in the masks. A randomized phase then mixes all op codes, including illegal ones, with warp numbers up to 31 against the default of eight warps, and with independent stall marks.

// File: rtl/warp_ctl_pkg.sv
package warp_ctl_pkg;
  typedef enum logic [2:0] {
    OP_TMC   = 3'd0,
    OP_SPAWN = 3'd1,
    OP_SPLIT = 3'd2,
    OP_JOIN  = 3'd3,
    OP_BAR   = 3'd4
  } wop_e;
  localparam int unsigned OP_W = 3;
endpackage

// File: rtl/warp_ctl_decode.sv
module warp_ctl_decode
  import warp_ctl_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned WID_W     = 5
) (
  input  logic                 fire_i,
  input  logic [OP_W-1:0]      op_i,
  input  logic [WID_W-1:0]     wid_i,
  output logic                 exec_o,
  output logic                 is_tmc_o,
  output logic                 is_spawn_o,
  output logic                 is_bar_o,
  output logic                 op_bad_o,
  output logic                 wid_bad_o,
  output logic [NUM_WARPS-1:0] wid_oh_o
);
  logic op_known;

  always_comb begin
    op_known = 1'b1;
    unique case (op_i)
      OP_TMC, OP_SPAWN, OP_SPLIT, OP_JOIN, OP_BAR: op_known = 1'b1;
      default: op_known = 1'b0;
    endcase
  end

  // extra top bit so the compare also works when NUM_WARPS == 2**WID_W
  assign wid_bad_o  = fire_i && ({1'b0, wid_i} >= (WID_W+1)'(NUM_WARPS));
  assign op_bad_o   = fire_i && !op_known;
  assign exec_o     = fire_i && op_known && !wid_bad_o;
  assign is_tmc_o   = (op_i == OP_TMC);
  assign is_spawn_o = (op_i == OP_SPAWN);
  assign is_bar_o   = (op_i == OP_BAR);

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_oh
    assign wid_oh_o[g] = (wid_i == WID_W'(g));
  end
endmodule

// File: rtl/warp_ctl_mask_upd.sv
module warp_ctl_mask_upd #(
  parameter int unsigned NUM_WARPS = 8
) (
  input  logic                 exec_i,
  input  logic                 is_tmc_i,
  input  logic                 is_spawn_i,
  input  logic                 is_bar_i,
  input  logic [NUM_WARPS-1:0] wid_oh_i,
  input  logic [NUM_WARPS-1:0] wmask_i,
  input  logic [NUM_WARPS-1:0] cur_i,
  output logic [NUM_WARPS-1:0] nxt_o
);
  logic bar_empty;
  assign bar_empty = (wmask_i == '0);

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_bit
    always_comb begin
      nxt_o[g] = cur_i[g];
      if (exec_i) begin
        if (is_spawn_i)                         nxt_o[g] = wmask_i[g];
        else if (is_tmc_i && wid_oh_i[g])       nxt_o[g] = wmask_i[g];
        else if (is_bar_i && !bar_empty)        nxt_o[g] = cur_i[g] | wmask_i[g];
        else if (is_bar_i && wid_oh_i[g])       nxt_o[g] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/warp_ctl_stall.sv
module warp_ctl_stall #(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned WID_W     = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [WID_W-1:0]     set_wid_i,
  input  logic [NUM_WARPS-1:0] clr_i,
  output logic [NUM_WARPS-1:0] stalled_o
);
  logic [NUM_WARPS-1:0] set_oh;
  logic [NUM_WARPS-1:0] stalled_q;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_set
    assign set_oh[g] = set_i && (set_wid_i == WID_W'(g));
  end

  // release from an issued instruction wins over a new mark
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stalled_q <= '0;
    else         stalled_q <= (stalled_q | set_oh) & ~clr_i;
  end

  assign stalled_o = stalled_q;
endmodule

// File: rtl/warp_ctl_unit.sv
module warp_ctl_unit
  import warp_ctl_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned WID_W     = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [2:0]           in_op_i,
  input  logic [WID_W-1:0]     in_wid_i,
  input  logic [NUM_WARPS-1:0] in_wmask_i,
  input  logic                 in_fstall_i,
  input  logic                 stall_set_i,
  input  logic [WID_W-1:0]     stall_set_wid_i,
  output logic [NUM_WARPS-1:0] active_mask_o,
  output logic [NUM_WARPS-1:0] stalled_mask_o,
  output logic                 done_valid_o,
  output logic [WID_W-1:0]     done_wid_o,
  output logic                 err_op_o,
  output logic                 err_wid_o
);
  localparam logic [NUM_WARPS-1:0] ACT_RST = NUM_WARPS'(1);

  logic                 rdy_q, fire, exec, is_tmc, is_spawn, is_bar, op_bad, wid_bad;
  logic [NUM_WARPS-1:0] wid_oh, act_q, act_d, stall_clr;
  logic                 done_q, eop_q, ewid_q;
  logic [WID_W-1:0]     dwid_q;

  assign fire = in_valid_i && rdy_q;

  warp_ctl_decode #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_dec (
    .fire_i(fire), .op_i(in_op_i), .wid_i(in_wid_i), .exec_o(exec),
    .is_tmc_o(is_tmc), .is_spawn_o(is_spawn), .is_bar_o(is_bar),
    .op_bad_o(op_bad), .wid_bad_o(wid_bad), .wid_oh_o(wid_oh)
  );

  warp_ctl_mask_upd #(.NUM_WARPS(NUM_WARPS)) u_upd (
    .exec_i(exec), .is_tmc_i(is_tmc), .is_spawn_i(is_spawn), .is_bar_i(is_bar),
    .wid_oh_i(wid_oh), .wmask_i(in_wmask_i), .cur_i(act_q), .nxt_o(act_d)
  );

  assign stall_clr = (exec && in_fstall_i) ? wid_oh : '0;

  warp_ctl_stall #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_stall (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stall_set_i),
    .set_wid_i(stall_set_wid_i), .clr_i(stall_clr), .stalled_o(stalled_mask_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      act_q  <= ACT_RST;
      done_q <= 1'b0;
      dwid_q <= '0;
      eop_q  <= 1'b0;
      ewid_q <= 1'b0;
    end else begin
      rdy_q  <= 1'b1;
      act_q  <= act_d;
      done_q <= exec;
      eop_q  <= op_bad;
      ewid_q <= wid_bad;
      if (exec) dwid_q <= in_wid_i;
    end
  end

  assign in_ready_o    = rdy_q;
  assign active_mask_o = act_q;
  assign done_valid_o  = done_q;
  assign done_wid_o    = dwid_q;
  assign err_op_o      = eop_q;
  assign err_wid_o     = ewid_q;
endmodule

// File: rtl/warp_ctl_chk.sv
module warp_ctl_chk #(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned WID_W     = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic                 in_ready_o,
  input logic [2:0]           in_op_i,
  input logic [WID_W-1:0]     in_wid_i,
  input logic [NUM_WARPS-1:0] in_wmask_i,
  input logic                 in_fstall_i,
  input logic                 stall_set_i,
  input logic [WID_W-1:0]     stall_set_wid_i,
  input logic [NUM_WARPS-1:0] active_mask_o,
  input logic [NUM_WARPS-1:0] stalled_mask_o,
  input logic                 done_valid_o,
  input logic [WID_W-1:0]     done_wid_o,
  input logic                 err_op_o,
  input logic                 err_wid_o
);
  logic acc, wid_in, op_ok, good;
  assign acc    = in_valid_i && in_ready_o;
  assign wid_in = ({1'b0, in_wid_i} < (WID_W+1)'(NUM_WARPS));
  assign op_ok  = (in_op_i <= 3'd4);
  assign good   = acc && wid_in && op_ok;

  AST_SPAWN_REPLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good && in_op_i == 3'd1 |=> active_mask_o == $past(in_wmask_i)); // R3
  AST_SPLIT_JOIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good && (in_op_i == 3'd2 || in_op_i == 3'd3) |=> $stable(active_mask_o)); // R5
  AST_DONE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good |=> done_valid_o && done_wid_o == $past(in_wid_i)); // R6
  AST_NO_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !done_valid_o && $stable(active_mask_o)); // R5
  AST_ILLEGAL_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !op_ok |=> err_op_o && !done_valid_o && $stable(active_mask_o)); // R8
  AST_BAD_WID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !wid_in |=> err_wid_o && !done_valid_o && $stable(active_mask_o)); // R9
  AST_BAR_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good && in_op_i == 3'd4 && in_wmask_i != '0
      |=> active_mask_o == ($past(active_mask_o) | $past(in_wmask_i))); // R4
  AST_ERR_ONLY_AFTER_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !err_op_o && !err_wid_o); // R8
endmodule

bind warp_ctl_unit warp_ctl_chk #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) chk_i (.*);

// File: tb/warp_ctl_unit_tb_top.sv
module warp_ctl_unit_tb_top;
  localparam int NW = 8;
  localparam int WW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = '0;
  logic [WW-1:0] in_wid = '0;
  logic [NW-1:0] in_wmask = '0;
  logic          in_fstall = 1'b0;
  logic          st_set = 1'b0;
  logic [WW-1:0] st_wid = '0;
  logic [NW-1:0] act, stl;
  logic          done_v, e_op, e_wid;
  logic [WW-1:0] done_w;

  int n_cmp = 0;
  int n_bad = 0;

  logic [NW-1:0] m_act = 8'h01;
  logic [NW-1:0] m_stl = '0;
  logic          m_done = 1'b0, m_eop = 1'b0, m_ewid = 1'b0;
  logic [WW-1:0] m_dw = '0;

  always #5 clk = ~clk;

  warp_ctl_unit #(.NUM_WARPS(NW), .WID_W(WW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_op_i(in_op), .in_wid_i(in_wid), .in_wmask_i(in_wmask), .in_fstall_i(in_fstall),
    .stall_set_i(st_set), .stall_set_wid_i(st_wid), .active_mask_o(act),
    .stalled_mask_o(stl), .done_valid_o(done_v), .done_wid_o(done_w),
    .err_op_o(e_op), .err_wid_o(e_wid)
  );

  task automatic chk(input string req, input string what, input logic [31:0] a, input logic [31:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, a, e);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, "ready", 32'(in_ready), 32'(1'b1));
    chk(req, "active", 32'(act), 32'(m_act));
    chk(req, "stalled", 32'(stl), 32'(m_stl));
    chk(req, "done", 32'(done_v), 32'(m_done));
    if (m_done) chk(req, "done_wid", 32'(done_w), 32'(m_dw));
    chk(req, "err_op", 32'(e_op), 32'(m_eop));
    chk(req, "err_wid", 32'(e_wid), 32'(m_ewid));
  endtask

  // one cycle: drive, model the edge, compare after it
  task automatic cyc(input string req, input bit v, input int op, input int wid,
                     input logic [NW-1:0] wm, input bit fs, input bit sv, input int sw);
    bit legal, inr, run;
    logic [NW-1:0] clr;
    in_valid = v; in_op = 3'(op); in_wid = WW'(wid); in_wmask = wm;
    in_fstall = fs; st_set = sv; st_wid = WW'(sw);
    @(posedge clk);
    legal = (op <= 4);
    inr   = (wid < NW);
    run   = v && legal && inr;
    clr   = '0;
    m_eop  = v && !legal;
    m_ewid = v && !inr;
    m_done = run;
    if (run) begin
      m_dw = WW'(wid);
      case (op)
        0: m_act[wid] = wm[wid];
        1: m_act = wm;
        4: if (wm != '0) m_act = m_act | wm; else m_act[wid] = 1'b0;
        default: ;
      endcase
      if (fs) clr[wid] = 1'b1;
    end
    if (sv && sw < NW) m_stl[sw] = 1'b1;
    m_stl = m_stl & ~clr;
    #1;
    compare_all(req);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #12;
    // R1 reset values
    chk("R1", "active", 32'(act), 32'h01);
    chk("R1", "stalled", 32'(stl), 32'h0);
    chk("R1", "done", 32'(done_v), 32'h0);
    chk("R1", "err", 32'({e_op, e_wid}), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "ready", 32'(in_ready), 32'h1);
    // R5 idle cycles hold state
    cyc("R5", 0, 0, 0, 8'hFF, 0, 0, 0);
    // R2 thread-mask control
    cyc("R2", 1, 0, 3, 8'h08, 0, 0, 0);
    cyc("R2", 1, 0, 0, 8'hFE, 0, 0, 0);
    cyc("R2", 1, 0, 6, 8'h00, 0, 0, 0);
    // R3 spawn
    cyc("R3", 1, 1, 2, 8'hA5, 0, 0, 0);
    cyc("R3", 1, 1, 7, 8'h3C, 0, 0, 0);
    // R4 barrier
    cyc("R4", 1, 4, 1, 8'h42, 0, 0, 0);
    cyc("R4", 1, 4, 5, 8'h00, 0, 0, 0);
    cyc("R4", 1, 4, 6, 8'h00, 0, 0, 0);
    // R5 split / join
    cyc("R5", 1, 2, 4, 8'hFF, 0, 0, 0);
    cyc("R5", 1, 3, 4, 8'h00, 0, 0, 0);
    // R7 stall mark and release
    cyc("R7", 0, 0, 0, 8'h00, 0, 1, 3);
    cyc("R7", 0, 0, 0, 8'h00, 0, 1, 6);
    cyc("R7", 1, 2, 3, 8'h00, 1, 0, 0);
    cyc("R7", 1, 3, 6, 8'h00, 1, 1, 6);
    cyc("R7", 0, 0, 0, 8'h00, 0, 1, 20);
    // R8 illegal op codes with non-zero operand
    cyc("R8", 1, 5, 2, 8'hFF, 1, 0, 0);
    cyc("R8", 1, 7, 0, 8'h00, 0, 0, 0);
    // R9 out-of-range warps
    cyc("R9", 1, 1, 8, 8'hFF, 0, 0, 0);
    cyc("R9", 1, 4, 31, 8'h00, 1, 0, 0);
    cyc("R6", 1, 0, 7, 8'h80, 0, 0, 0);
    cyc("R6", 0, 0, 0, 8'h00, 0, 0, 0);
    // mixed random phase
    for (int i = 0; i < 400; i++) begin
      int op, wid, sw;
      op  = int'($urandom_range(0, 7));
      wid = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 31)) : int'($urandom_range(0, 7));
      sw  = int'($urandom_range(0, 9));
      cyc("R6", 1'($urandom_range(0, 1)), op, wid, NW'($urandom), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), sw);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule